// File: doc/BRIEF.md
# Privilege-Filtered Performance Counter Bank

This block holds a small bank of 32-bit event counters for a processor core. Each counter has its own control register that picks one line from a vector of per-cycle event pulses, together with the privilege modes and the thread in which counting is allowed. Software reads and writes every control and count register through a simple register-access port. It can find out how many counters exist by following a chain bit through the control registers.

A counter is treated as overflowed as soon as its top bit (bit 31) is set. The counter does not have to wrap for this. Software therefore arms a counter by loading it with 0x80000000 minus N, so that the N-th qualifying event raises the interrupt. The bank drives one combined, registered interrupt request. The same pending condition can be read in a status word, and a capability word tells software that counters are present.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every control and count register reads 0 (apart from the chain bit), the interrupt output is low, and the capability word (address 9) reads 0x00000010 (bit 4 set).
- R2: Register map: address 2*i is the control register of counter i and address 2*i+1 is its count. Bit 31 of control register i reads 1 exactly when counter i+1 exists. Bits 30 and 15 always read 0, and writes to bits 31, 30 and 15 are ignored. Addresses of counters that are not implemented read 0.
- R3: A counter increases by exactly one on each clock in which the event line selected by control bits 14:5 is high and both filters pass. An event select at or above the number of event lines never counts.
- R4: Mode filter. When the exception-level input is high, counting needs control bit 0. Otherwise privilege code 0 (kernel) needs bit 1, code 1 (supervisor) needs bit 2 and code 2 (user) needs bit 3. Code 3 never counts.
- R5: Thread filter in control bits 21:20. Value 0 counts for any thread. Value 1 counts only when the current VPE id equals bits 19:16. Value 2 counts only when the current TC id equals bits 29:22. Value 3 never counts.
- R6: A software write to a count register takes priority over an increment in the same cycle. Writing 0 to a control register stops that counter.
- R7: One clock after some counter has bit 31 set while its control bit 4 (interrupt enable) is set, the interrupt output is high. With bit 4 clear, an overflowed counter raises no interrupt.
- R8: The interrupt output stays high until every overflowed counter has been rewritten with bit 31 clear or has had its interrupt enable cleared. It drops one clock after that write.
- R9: The status word (address 8) has bit 26 equal to the pending condition of R7, and all of its other bits read 0.
- R10: A counter preloaded with 0x80000000 minus N raises the interrupt after exactly N qualifying events and not after N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one clock later |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | EVT_NUM | Per-cycle event pulses |
| at_exl | input | 1 | Core is at exception level |
| priv_mode | input | 2 | Privilege code: 0 kernel, 1 supervisor, 2 user |
| cur_vpe | input | 4 | Current VPE identifier |
| cur_tc | input | 8 | Current TC identifier |
| irq | output | 1 | Registered combined overflow interrupt |

## Verification
The bench builds the bank with three counters and eight event lines. With three counters the chain bit has to read 1 on the first two control registers and 0 on the last one, and the addresses of the missing fourth counter must read 0. With eight event lines, event selects above the implemented range can be tried using an ordinary 10-bit field value. Interrupt timing is checked to the exact clock, both on a counter crossing from 0x7FFFFFFF to 0x80000000 and on a preloaded countdown.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int CW = 32;
  // control register field positions
  localparam int B_EXL   = 0;
  localparam int B_KERN  = 1;
  localparam int B_SUPER = 2;
  localparam int B_USER  = 3;
  localparam int B_IE    = 4;
  localparam int EVS_LO  = 5;
  localparam int EVS_HI  = 14;
  localparam int VPE_LO  = 16;
  localparam int VPE_HI  = 19;
  localparam int TFM_LO  = 20;
  localparam int TFM_HI  = 21;
  localparam int TC_LO   = 22;
  localparam int TC_HI   = 29;
  localparam logic [29:0] CTRL_WMASK = 30'h3FFF_7FFF;
  // register map
  localparam logic [3:0] ADDR_STATUS = 4'd8;
  localparam logic [3:0] ADDR_CAP    = 4'd9;
  localparam int STATUS_PEND_BIT = 26;
  localparam int CAP_PRESENT_BIT = 4;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_NONE   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    TF_ANY  = 2'd0,
    TF_VPE  = 2'd1,
    TF_TC   = 2'd2,
    TF_NONE = 2'd3
  } tfilt_e;
endpackage

// File: rtl/perf_mode_filter.sv
module perf_mode_filter
  import perf_pkg::*;
(
  input  logic [3:0] mode_en,
  input  logic [1:0] tf_mode,
  input  logic [3:0] vpe_sel,
  input  logic [7:0] tc_sel,
  input  logic       at_exl,
  input  logic [1:0] priv_mode,
  input  logic [3:0] cur_vpe,
  input  logic [7:0] cur_tc,
  output logic       mode_ok,
  output logic       thread_ok
);
  always_comb begin
    if (at_exl) begin
      mode_ok = mode_en[B_EXL];
    end else begin
      unique case (priv_e'(priv_mode))
        PRIV_KERNEL: mode_ok = mode_en[B_KERN];
        PRIV_SUPER:  mode_ok = mode_en[B_SUPER];
        PRIV_USER:   mode_ok = mode_en[B_USER];
        default:     mode_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (tfilt_e'(tf_mode))
      TF_ANY:  thread_ok = 1'b1;
      TF_VPE:  thread_ok = (cur_vpe == vpe_sel);
      TF_TC:   thread_ok = (cur_tc == tc_sel);
      default: thread_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice
  import perf_pkg::*;
#(
  parameter int EVT_NUM  = 16,
  parameter bit HAS_NEXT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  logic               cnt_we,
  input  logic [CW-1:0]      wdata,
  input  logic [EVT_NUM-1:0] evt,
  input  logic               at_exl,
  input  logic [1:0]         priv_mode,
  input  logic [3:0]         cur_vpe,
  input  logic [7:0]         cur_tc,
  output logic [CW-1:0]      ctrl_rd,
  output logic [CW-1:0]      cnt_q,
  output logic               pend
);
  logic [29:0]        ctrl_q;
  logic               mode_ok, thread_ok;
  logic [9:0]         evsel;
  logic [EVT_NUM-1:0] evt_shift;
  logic               hit, inc;

  perf_mode_filter u_filt (
    .mode_en   (ctrl_q[B_USER:B_EXL]),
    .tf_mode   (ctrl_q[TFM_HI:TFM_LO]),
    .vpe_sel   (ctrl_q[VPE_HI:VPE_LO]),
    .tc_sel    (ctrl_q[TC_HI:TC_LO]),
    .at_exl    (at_exl),
    .priv_mode (priv_mode),
    .cur_vpe   (cur_vpe),
    .cur_tc    (cur_tc),
    .mode_ok   (mode_ok),
    .thread_ok (thread_ok)
  );

  assign evsel     = ctrl_q[EVS_HI:EVS_LO];
  assign evt_shift = evt >> evsel;
  assign hit       = evt_shift[0] && (32'(evsel) < EVT_NUM);
  assign inc       = hit && mode_ok && thread_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata[29:0] & CTRL_WMASK;
      if (cnt_we)   cnt_q <= wdata;
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ctrl_rd = {HAS_NEXT, 1'b0, ctrl_q};
  assign pend    = cnt_q[CW-1] && ctrl_q[B_IE];

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst) !cnt_we |=> ((cnt_q - $past(cnt_q)) <= 32'd1)); // R3
  AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (rst) (!cnt_we && !mode_ok) |=> $stable(cnt_q)); // R4
  AST_THREAD_BLOCK: assert property (@(posedge clk) disable iff (rst) (!cnt_we && !thread_ok) |=> $stable(cnt_q)); // R5
  AST_STOPPED: assert property (@(posedge clk) disable iff (rst) (!cnt_we && ctrl_q[B_USER:B_EXL] == 4'd0) |=> $stable(cnt_q)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst) cnt_we |=> (cnt_q == $past(wdata))); // R6
endmodule

// File: rtl/perf_read_mux.sv
module perf_read_mux
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic [NUM_CTR-1:0][CW-1:0] ctrl_v,
  input  logic [NUM_CTR-1:0][CW-1:0] cnt_v,
  input  logic [3:0]                 addr,
  input  logic                       pend_any,
  output logic [CW-1:0]              data
);
  always_comb begin
    data = '0;
    if (addr == ADDR_STATUS) begin
      data[STATUS_PEND_BIT] = pend_any;
    end else if (addr == ADDR_CAP) begin
      data[CAP_PRESENT_BIT] = 1'b1;
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (addr == 4'(2 * i))     data = ctrl_v[i];
        if (addr == 4'(2 * i + 1)) data = cnt_v[i];
      end
    end
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int EVT_NUM = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [3:0]         reg_addr,
  input  logic [CW-1:0]      reg_wdata,
  output logic [CW-1:0]      reg_rdata,
  input  logic [EVT_NUM-1:0] evt_pulse,
  input  logic               at_exl,
  input  logic [1:0]         priv_mode,
  input  logic [3:0]         cur_vpe,
  input  logic [7:0]         cur_tc,
  output logic               irq
);
  localparam int LAST = NUM_CTR - 1;

  logic [NUM_CTR-1:0][CW-1:0] ctrl_v;
  logic [NUM_CTR-1:0][CW-1:0] cnt_v;
  logic [NUM_CTR-1:0]         pend_v;
  logic                       pend_any;
  logic [CW-1:0]              rd_mux;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    perf_ctr_slice #(
      .EVT_NUM  (EVT_NUM),
      .HAS_NEXT (i < LAST)
    ) u_slice (
      .clk       (clk),
      .rst       (rst),
      .ctrl_we   (reg_wr && reg_addr == 4'(2 * i)),
      .cnt_we    (reg_wr && reg_addr == 4'(2 * i + 1)),
      .wdata     (reg_wdata),
      .evt       (evt_pulse),
      .at_exl    (at_exl),
      .priv_mode (priv_mode),
      .cur_vpe   (cur_vpe),
      .cur_tc    (cur_tc),
      .ctrl_rd   (ctrl_v[i]),
      .cnt_q     (cnt_v[i]),
      .pend      (pend_v[i])
    );
  end

  assign pend_any = |pend_v;

  perf_read_mux #(.NUM_CTR(NUM_CTR)) u_rmux (
    .ctrl_v   (ctrl_v),
    .cnt_v    (cnt_v),
    .addr     (reg_addr),
    .pend_any (pend_any),
    .data     (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= pend_any;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  AST_IRQ_RESET: assert property (@(posedge clk) $past(rst) |-> !irq); // R1
  AST_WIDE_ZERO: assert property (@(posedge clk) disable iff (rst) ctrl_v[0][30] == 1'b0); // R2
  AST_LAST_NO_MORE: assert property (@(posedge clk) disable iff (rst) ctrl_v[LAST][31] == 1'b0); // R2
  AST_STATUS_ONLY26: assert property (@(posedge clk) disable iff (rst) (reg_rd && reg_addr == ADDR_STATUS) |=> (reg_rdata[25:0] == '0 && reg_rdata[31:27] == '0)); // R9
endmodule

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;
  localparam int NC = 3;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NE-1:0] evt_pulse = '0;
  logic          at_exl = 1'b0;
  logic [1:0]    priv_mode = 2'd0;
  logic [3:0]    cur_vpe = '0;
  logic [7:0]    cur_tc = '0;
  logic          irq;
  int checks = 0, failures = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  perf_counter_bank #(.NUM_CTR(NC), .EVT_NUM(NE)) u_perf_counter_bank (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .at_exl(at_exl), .priv_mode(priv_mode), .cur_vpe(cur_vpe), .cur_tc(cur_tc), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] m, input int n);
    evt_pulse = m;
    repeat (n) @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'd1, v); chk("R1 count0", v, 32'd0);
    rd(4'd9, v); chk("R1 capability", v, 32'h10);
    rd(4'd8, v); chk("R9 status idle", v, 32'd0);
  endtask

  task automatic t_chain;
    rd(4'd0, v); chk("R2 ctrl0 more", v, 32'h8000_0000);
    rd(4'd2, v); chk("R2 ctrl1 more", v, 32'h8000_0000);
    rd(4'd4, v); chk("R2 ctrl2 last", v, 32'h0);
    rd(4'd6, v); chk("R2 missing ctrl", v, 32'h0);
    wr(4'd7, 32'h1234_5678);
    rd(4'd7, v); chk("R2 missing count", v, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R2 read-only bits", v, 32'hBFFF_7FFF);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v); chk("R2 last ro bits", v, 32'h3FFF_7FFF);
    wr(4'd0, 32'h0); wr(4'd4, 32'h0); wr(4'd5, 32'h0);
  endtask

  task automatic t_modes;
    wr(4'd1, 32'h0);
    wr(4'd0, (32'd2 << 5) | 32'h2);           // event 2, kernel
    priv_mode = 2'd0; at_exl = 1'b0;
    pulse(8'h04, 5);
    rd(4'd1, v); chk("R3 kernel count", v, 32'd5);
    pulse(8'hFB, 4);
    rd(4'd1, v); chk("R3 other event", v, 32'd5);
    priv_mode = 2'd2;
    pulse(8'h04, 3);
    rd(4'd1, v); chk("R4 user blocked", v, 32'd5);
    wr(4'd0, (32'd2 << 5) | 32'h8);           // user only
    pulse(8'h04, 2);
    rd(4'd1, v); chk("R4 user counts", v, 32'd7);
    priv_mode = 2'd1;
    pulse(8'h04, 2);
    rd(4'd1, v); chk("R4 super blocked", v, 32'd7);
    at_exl = 1'b1; priv_mode = 2'd2;
    pulse(8'h04, 2);
    rd(4'd1, v); chk("R4 exl blocked", v, 32'd7);
    wr(4'd0, (32'd2 << 5) | 32'h1);
    pulse(8'h04, 3);
    rd(4'd1, v); chk("R4 exl counts", v, 32'd10);
    at_exl = 1'b0; priv_mode = 2'd3;
    wr(4'd0, (32'd2 << 5) | 32'hE);
    pulse(8'h04, 2);
    rd(4'd1, v); chk("R4 code3 never", v, 32'd10);
    priv_mode = 2'd0;
    wr(4'd0, (32'd9 << 5) | 32'h2);           // out of range event
    pulse(8'hFF, 4);
    rd(4'd1, v); chk("R3 event out of range", v, 32'd10);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_thread;
    wr(4'd3, 32'h0);
    wr(4'd2, (32'd1 << 5) | 32'h2 | (32'd1 << 20) | (32'd5 << 16));
    cur_vpe = 4'd3;
    pulse(8'h02, 3);
    rd(4'd3, v); chk("R5 vpe mismatch", v, 32'd0);
    cur_vpe = 4'd5;
    pulse(8'h02, 3);
    rd(4'd3, v); chk("R5 vpe match", v, 32'd3);
    wr(4'd2, (32'd1 << 5) | 32'h2 | (32'd2 << 20) | (32'h2A << 22));
    cur_tc = 8'h2B;
    pulse(8'h02, 2);
    rd(4'd3, v); chk("R5 tc mismatch", v, 32'd3);
    cur_tc = 8'h2A;
    pulse(8'h02, 2);
    rd(4'd3, v); chk("R5 tc match", v, 32'd5);
    wr(4'd2, (32'd1 << 5) | 32'h2 | (32'd3 << 20));
    pulse(8'h02, 2);
    rd(4'd3, v); chk("R5 mode3 never", v, 32'd5);
    wr(4'd2, (32'd1 << 5) | 32'h2);
    pulse(8'h02, 1);
    rd(4'd3, v); chk("R5 any thread", v, 32'd6);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_write_prio;
    wr(4'd0, (32'd3 << 5) | 32'h2);
    evt_pulse = 8'h08;
    wr(4'd1, 32'd100);
    evt_pulse = '0;
    rd(4'd1, v); chk("R6 write wins", v, 32'd100);
    wr(4'd0, 32'h0);
    pulse(8'h08, 4);
    rd(4'd1, v); chk("R6 stopped", v, 32'd100);
  endtask

  task automatic t_overflow;
    wr(4'd3, 32'h7FFF_FFFE);
    wr(4'd2, (32'd1 << 5) | 32'h2 | 32'h10);
    pulse(8'h02, 1);
    @(negedge clk);
    chk("R7 below bit31", {31'd0, irq}, 32'd0);
    pulse(8'h02, 1);
    chk("R7 same cycle", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R7 one clock later", {31'd0, irq}, 32'd1);
    rd(4'd8, v); chk("R9 status pending", v, 32'h0400_0000);
    repeat (5) @(negedge clk);
    chk("R8 held", {31'd0, irq}, 32'd1);
    wr(4'd2, (32'd1 << 5) | 32'h2);           // clear ie
    chk("R8 drop pending", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R8 ie cleared", {31'd0, irq}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R7 no ie no irq", {31'd0, irq}, 32'd0);
    rd(4'd8, v); chk("R9 status clear", v, 32'h0);
    wr(4'd2, 32'h0); wr(4'd3, 32'h0);
  endtask

  task automatic t_preload;
    wr(4'd5, 32'h8000_0000 - 32'd4);
    wr(4'd4, (32'd6 << 5) | 32'h2 | 32'h10);
    pulse(8'h40, 3);
    repeat (2) @(negedge clk);
    chk("R10 after N-1", {31'd0, irq}, 32'd0);
    pulse(8'h40, 1);
    @(negedge clk);
    chk("R10 after N", {31'd0, irq}, 32'd1);
    wr(4'd5, 32'h0);
    @(negedge clk);
    chk("R8 rewrite clears", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_chain();
    t_modes();
    t_thread();
    t_write_prio();
    t_overflow();
    t_preload();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule